// File: doc/BRIEF.md
# Token-Counting Coherence Line Controller

This block is the per-node controller for a small set of tracked cache blocks in a coherence scheme where permission comes from counting tokens. Each block has a fixed number of tokens in the whole system. The controller keeps, for every tracked block, how many of those tokens the node holds and whether it holds valid data. A local load is granted while the node holds at least one token for the block. A local store is granted only while it holds all of them.

When the local core asks for an access it cannot yet perform, the controller sends a transient request and waits. If the request is still unsatisfied after a timeout, it sends the request again. After a fixed number of failed attempts it waits a longer timeout and then sends a persistent request to the arbiter. Once its access is granted it sends a deactivate message. The controller also keeps a table of the persistent requests that the arbiter has activated, one entry per block. While an entry names another node, every token the controller holds or later receives for that block goes straight to that node, together with the data. A replacement is a single message that carries all of the block's tokens, and its data flag, back to memory. No handshake is needed.

Top module: `tokc_node`

## Requirements
- R1: After reset the node holds no tokens for any block. Every outgoing token message carries exactly the tokens held for its block, and the block's count is zero afterwards.
- R2: A load request is granted (op_done high in the same cycle) when the block's count is one or more.
- R3: A store request is granted in the same cycle only when the block's count equals TOTAL_TOKENS. It is never granted with fewer tokens.
- R4: Tokens arriving on the response port are always added to the block's count, including when no request is outstanding.
- R5: An access that is not granted sends a transient request in the next cycle. An unsatisfied request is sent again REQ_TIMEOUT+1 cycles after the previous send, and at most MAX_RETRY transient sends are made.
- R6: After the MAX_RETRY-th transient send, the persistent request appears REQ_TIMEOUT+PERSIST_TIMEOUT+1 cycles later. At most one of transient request, persistent request and deactivate is valid at a time.
- R7: Once the access under a persistent request is granted, a deactivate for that block is valid in the next cycle, for one cycle when accepted.
- R8: An activate table message (ptab_activate=1) for a block naming another node makes the node forward all held and later received tokens of that block, with its data flag, to that node (tok_to_mem=0, tok_dest=node). An entry naming this node forwards nothing.
- R9: An activate for a block already in the table replaces its requester. A deactivate message (ptab_activate=0) stops the forwarding, so that later tokens stay local.
- R10: A replacement sends one message to memory (tok_to_mem=1) with all of the block's tokens and its data flag. Replacing a block that holds no tokens is accepted at once and sends nothing.
- R11: A pending forward takes the token channel before a replacement. The replacement is held off (evict_ready=0) until no forward is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Core access request, held until op_done |
| op_store | input | 1 | 1 = store, 0 = load |
| op_blk | input | BLK_W | Block of the core access |
| op_done | output | 1 | Access granted this cycle |
| rsp_valid | input | 1 | Incoming token message (always accepted) |
| rsp_blk | input | BLK_W | Block of incoming tokens |
| rsp_tokens | input | CNT_W | Number of tokens received |
| rsp_data | input | 1 | Incoming message carries data |
| ptab_valid | input | 1 | Persistent-table update from the arbiter |
| ptab_activate | input | 1 | 1 = activate, 0 = deactivate |
| ptab_blk | input | BLK_W | Block of the table update |
| ptab_node | input | NODE_W | Requester named by an activate |
| evict_valid | input | 1 | Replacement command |
| evict_blk | input | BLK_W | Block to replace |
| evict_ready | output | 1 | Replacement accepted |
| tok_valid | output | 1 | Outgoing token message |
| tok_ready | input | 1 | Interconnect takes the token message |
| tok_blk | output | BLK_W | Block of outgoing tokens |
| tok_tokens | output | CNT_W | Number of tokens sent |
| tok_data | output | 1 | Data travels with the tokens |
| tok_to_mem | output | 1 | 1 = to memory, 0 = to tok_dest |
| tok_dest | output | NODE_W | Destination node of a forward |
| treq_valid | output | 1 | Transient request |
| treq_ready | input | 1 | Transient request taken |
| treq_blk | output | BLK_W | Block requested |
| treq_store | output | 1 | Request wants write permission |
| preq_valid | output | 1 | Persistent request to the arbiter |
| preq_ready | input | 1 | Persistent request taken |
| preq_blk | output | BLK_W | Block of persistent request |
| preq_store | output | 1 | Persistent request wants write permission |
| deact_valid | output | 1 | Deactivate to the arbiter |
| deact_ready | input | 1 | Deactivate taken |
| deact_blk | output | BLK_W | Block being released |

## Verification
The checks assume that the core holds a request, unchanged, until it is granted. They also assume that the system never delivers tokens beyond the fixed total for a block, and that the arbiter's table messages name valid nodes. The stimulus meets these conditions because the bench acts as the rest of the system: it keeps a per-block ledger of the tokens it has handed to the node and the tokens it has received back, and it only delivers tokens from that ledger. Requests stay asserted until op_done. Response, table and replacement traffic is kept apart from the cycles in which a forward or replacement of the same block is taken. This keeps every message's token count predictable from the ledger alone.

// File: rtl/tokc_pkg.sv
package tokc_pkg;

   typedef enum logic [2:0] {
      RQ_IDLE,
      RQ_TSEND,
      RQ_TWAIT,
      RQ_PWAIT,
      RQ_PSEND,
      RQ_PHELD,
      RQ_DSEND
   } rq_state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tokc_lines.sv
module tokc_lines #(
   parameter int NB = 4,
   parameter int CW = 3,
   parameter int BW = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  add_en,
   input  logic [BW-1:0]         add_blk,
   input  logic [CW-1:0]         add_tok,
   input  logic                  add_dat,
   input  logic                  clr_en,
   input  logic [BW-1:0]         clr_blk,
   input  logic                  wr_en,
   input  logic [BW-1:0]         wr_blk,
   output logic [NB-1:0][CW-1:0] cnt_o,
   output logic [NB-1:0]         dv_o
);

   for (genvar b = 0; b < NB; b++) begin : g_line
      logic hit_add, hit_clr, hit_wr;
      logic [CW-1:0] base;
      assign hit_add = add_en && (add_blk == BW'(b));
      assign hit_clr = clr_en && (clr_blk == BW'(b));
      assign hit_wr  = wr_en  && (wr_blk  == BW'(b));
      assign base    = hit_clr ? '0 : cnt_o[b];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_o[b] <= '0;
            dv_o[b]  <= 1'b0;
         end else begin
            cnt_o[b] <= hit_add ? base + add_tok : base;
            if (hit_add && add_dat)
               dv_o[b] <= 1'b1;
            else if (hit_clr)
               dv_o[b] <= 1'b0;
            else if (hit_wr)
               dv_o[b] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/tokc_ptable.sv
module tokc_ptable #(
   parameter int NB = 4,
   parameter int BW = 2,
   parameter int NW = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  upd_en,
   input  logic                  upd_act,
   input  logic [BW-1:0]         upd_blk,
   input  logic [NW-1:0]         upd_node,
   output logic [NB-1:0]         act_o,
   output logic [NB-1:0][NW-1:0] node_o
);

   for (genvar b = 0; b < NB; b++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            act_o[b]  <= 1'b0;
            node_o[b] <= '0;
         end else if (upd_en && upd_blk == BW'(b)) begin
            act_o[b] <= upd_act;
            if (upd_act)
               node_o[b] <= upd_node;
         end
      end
   end

endmodule

// File: rtl/tokc_retry.sv
module tokc_retry
   import tokc_pkg::*;
#(
   parameter int BW = 2,
   parameter int REQ_TIMEOUT = 8,
   parameter int PERSIST_TIMEOUT = 32,
   parameter int MAX_RETRY = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          miss,
   input  logic          op_store,
   input  logic [BW-1:0] op_blk,
   input  logic          req_perm,
   input  logic          treq_ready,
   input  logic          preq_ready,
   input  logic          deact_ready,
   output logic [BW-1:0] req_blk,
   output logic          req_store,
   output logic          treq_valid,
   output logic          preq_valid,
   output logic          deact_valid
);

   localparam int TW = $clog2(max2(REQ_TIMEOUT, PERSIST_TIMEOUT) + 1);
   localparam int RW = $clog2(MAX_RETRY + 1);

   rq_state_e     st;
   logic [TW-1:0] tmr;
   logic [RW-1:0] tries;

   assign treq_valid  = (st == RQ_TSEND);
   assign preq_valid  = (st == RQ_PSEND);
   assign deact_valid = (st == RQ_DSEND);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= RQ_IDLE;
         tmr       <= '0;
         tries     <= '0;
         req_blk   <= '0;
         req_store <= 1'b0;
      end else begin
         unique case (st)
            RQ_IDLE: if (miss) begin
               req_blk   <= op_blk;
               req_store <= op_store;
               tries     <= '0;
               st        <= RQ_TSEND;
            end
            RQ_TSEND: if (treq_ready) begin
               tmr <= '0;
               st  <= RQ_TWAIT;
            end
            RQ_TWAIT: begin
               if (req_perm)
                  st <= RQ_IDLE;
               else if (tmr == TW'(REQ_TIMEOUT - 1)) begin
                  tmr <= '0;
                  if (tries == RW'(MAX_RETRY - 1))
                     st <= RQ_PWAIT;
                  else begin
                     tries <= tries + 1'b1;
                     st    <= RQ_TSEND;
                  end
               end else
                  tmr <= tmr + 1'b1;
            end
            RQ_PWAIT: begin
               if (req_perm)
                  st <= RQ_IDLE;
               else if (tmr == TW'(PERSIST_TIMEOUT - 1))
                  st <= RQ_PSEND;
               else
                  tmr <= tmr + 1'b1;
            end
            RQ_PSEND: if (preq_ready) st <= RQ_PHELD;
            RQ_PHELD: if (req_perm)   st <= RQ_DSEND;
            RQ_DSEND: if (deact_ready) st <= RQ_IDLE;
            default:  st <= RQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/tokc_node.sv
module tokc_node
   import tokc_pkg::*;
#(
   parameter int NUM_BLOCKS      = 4,
   parameter int TOTAL_TOKENS    = 4,
   parameter int NUM_NODES       = 4,
   parameter int NODE_ID         = 0,
   parameter int REQ_TIMEOUT     = 8,
   parameter int PERSIST_TIMEOUT = 32,
   parameter int MAX_RETRY       = 4,
   localparam int BLK_W  = $clog2(NUM_BLOCKS),
   localparam int CNT_W  = $clog2(TOTAL_TOKENS + 1),
   localparam int NODE_W = $clog2(NUM_NODES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic              op_store,
   input  logic [BLK_W-1:0]  op_blk,
   output logic              op_done,
   input  logic              rsp_valid,
   input  logic [BLK_W-1:0]  rsp_blk,
   input  logic [CNT_W-1:0]  rsp_tokens,
   input  logic              rsp_data,
   input  logic              ptab_valid,
   input  logic              ptab_activate,
   input  logic [BLK_W-1:0]  ptab_blk,
   input  logic [NODE_W-1:0] ptab_node,
   input  logic              evict_valid,
   input  logic [BLK_W-1:0]  evict_blk,
   output logic              evict_ready,
   output logic              tok_valid,
   input  logic              tok_ready,
   output logic [BLK_W-1:0]  tok_blk,
   output logic [CNT_W-1:0]  tok_tokens,
   output logic              tok_data,
   output logic              tok_to_mem,
   output logic [NODE_W-1:0] tok_dest,
   output logic              treq_valid,
   input  logic              treq_ready,
   output logic [BLK_W-1:0]  treq_blk,
   output logic              treq_store,
   output logic              preq_valid,
   input  logic              preq_ready,
   output logic [BLK_W-1:0]  preq_blk,
   output logic              preq_store,
   output logic              deact_valid,
   input  logic              deact_ready,
   output logic [BLK_W-1:0]  deact_blk
);

   if (NUM_BLOCKS < 2 || (1 << BLK_W) != NUM_BLOCKS) begin : g_bad_nb
      $error("NUM_BLOCKS must be a power of two, at least 2");
   end
   if (NUM_NODES < 2 || NODE_ID >= NUM_NODES) begin : g_bad_node
      $error("NODE_ID must lie below NUM_NODES, NUM_NODES at least 2");
   end
   if (TOTAL_TOKENS < 1 || REQ_TIMEOUT < 1 || PERSIST_TIMEOUT < 1 || MAX_RETRY < 1) begin : g_bad_cfg
      $error("token total, timeouts and retry limit must be positive");
   end

   logic [NUM_BLOCKS-1:0][CNT_W-1:0]  cnt_q;
   logic [NUM_BLOCKS-1:0]             dv_q;
   logic [NUM_BLOCKS-1:0]             pt_act;
   logic [NUM_BLOCKS-1:0][NODE_W-1:0] pt_node;
   logic [BLK_W-1:0]                  req_blk;
   logic                              req_store, req_perm, miss;
   logic                              fwd_pend, ev_has, send;
   logic [BLK_W-1:0]                  fwd_blk;

   function automatic logic allowed(input logic [CNT_W-1:0] c, input logic st);
      return st ? (c == CNT_W'(TOTAL_TOKENS)) : (c != '0);
   endfunction

   assign op_done  = op_valid && allowed(cnt_q[op_blk], op_store);
   assign miss     = op_valid && !op_done;
   assign req_perm = allowed(cnt_q[req_blk], req_store);

   always_comb begin
      fwd_pend = 1'b0;
      fwd_blk  = '0;
      for (int b = NUM_BLOCKS - 1; b >= 0; b--) begin
         if (pt_act[b] && pt_node[b] != NODE_W'(NODE_ID) && cnt_q[b] != '0) begin
            fwd_pend = 1'b1;
            fwd_blk  = BLK_W'(b);
         end
      end
   end

   assign ev_has      = (cnt_q[evict_blk] != '0);
   assign tok_valid   = fwd_pend || (evict_valid && ev_has);
   assign tok_blk     = fwd_pend ? fwd_blk : evict_blk;
   assign tok_tokens  = cnt_q[tok_blk];
   assign tok_data    = dv_q[tok_blk];
   assign tok_to_mem  = !fwd_pend;
   assign tok_dest    = fwd_pend ? pt_node[fwd_blk] : '0;
   assign evict_ready = !fwd_pend && (!ev_has || tok_ready);
   assign send        = tok_valid && tok_ready;

   assign treq_blk   = req_blk;
   assign treq_store = req_store;
   assign preq_blk   = req_blk;
   assign preq_store = req_store;
   assign deact_blk  = req_blk;

   tokc_lines #(.NB(NUM_BLOCKS), .CW(CNT_W), .BW(BLK_W)) i_lines (
      .clk     (clk),
      .rst_n   (rst_n),
      .add_en  (rsp_valid),
      .add_blk (rsp_blk),
      .add_tok (rsp_tokens),
      .add_dat (rsp_data),
      .clr_en  (send),
      .clr_blk (tok_blk),
      .wr_en   (op_done && op_store),
      .wr_blk  (op_blk),
      .cnt_o   (cnt_q),
      .dv_o    (dv_q)
   );

   tokc_ptable #(.NB(NUM_BLOCKS), .BW(BLK_W), .NW(NODE_W)) i_ptable (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (ptab_valid),
      .upd_act  (ptab_activate),
      .upd_blk  (ptab_blk),
      .upd_node (ptab_node),
      .act_o    (pt_act),
      .node_o   (pt_node)
   );

   tokc_retry #(
      .BW              (BLK_W),
      .REQ_TIMEOUT     (REQ_TIMEOUT),
      .PERSIST_TIMEOUT (PERSIST_TIMEOUT),
      .MAX_RETRY       (MAX_RETRY)
   ) i_retry (
      .clk         (clk),
      .rst_n       (rst_n),
      .miss        (miss),
      .op_store    (op_store),
      .op_blk      (op_blk),
      .req_perm    (req_perm),
      .treq_ready  (treq_ready),
      .preq_ready  (preq_ready),
      .deact_ready (deact_ready),
      .req_blk     (req_blk),
      .req_store   (req_store),
      .treq_valid  (treq_valid),
      .preq_valid  (preq_valid),
      .deact_valid (deact_valid)
   );

endmodule

// File: rtl/tokc_node_chk.sv
module tokc_node_chk #(
   parameter int NB = 4,
   parameter int T  = 4,
   parameter int BW = 2,
   parameter int CW = 3,
   parameter int NW = 2,
   parameter int NODE_ID = 0
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NB-1:0][CW-1:0] cnt,
   input logic                  op_done,
   input logic                  tok_valid,
   input logic                  tok_ready,
   input logic [BW-1:0]         tok_blk,
   input logic [CW-1:0]         tok_tokens,
   input logic                  tok_to_mem,
   input logic [NW-1:0]         tok_dest,
   input logic                  rsp_valid,
   input logic [BW-1:0]         rsp_blk,
   input logic                  treq_valid,
   input logic                  treq_ready,
   input logic [BW-1:0]         treq_blk,
   input logic                  preq_valid,
   input logic                  deact_valid
);

   for (genvar b = 0; b < NB; b++) begin : g_blk
      // R1: a node never holds more than the system total
      a_r1_cnt_limit: assert property (@(posedge clk) disable iff (!rst_n)
         cnt[b] <= CW'(T));
   end

   // R1: a taken token message leaves the block empty
   a_r1_send_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && tok_ready && !(rsp_valid && rsp_blk == tok_blk))
      |=> cnt[$past(tok_blk)] == '0);

   // R10: no empty token messages
   a_r10_nonempty_message: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid |-> tok_tokens != '0);

   // R8: forwards never target this node
   a_r8_no_self_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && !tok_to_mem) |-> tok_dest != NW'(NODE_ID));

   // R5: a transient request holds until taken
   a_r5_treq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (treq_valid && !treq_ready) |=> (treq_valid && $stable(treq_blk)));

   // R6: one request-side message at a time
   a_r6_one_request: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({treq_valid, preq_valid, deact_valid}));

   // R7: deactivate only follows a grant
   a_r7_deact_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(deact_valid) |-> $past(op_done));

endmodule

bind tokc_node tokc_node_chk #(
   .NB(NUM_BLOCKS), .T(TOTAL_TOKENS), .BW(BLK_W), .CW(CNT_W), .NW(NODE_W), .NODE_ID(NODE_ID)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cnt         (cnt_q),
   .op_done     (op_done),
   .tok_valid   (tok_valid),
   .tok_ready   (tok_ready),
   .tok_blk     (tok_blk),
   .tok_tokens  (tok_tokens),
   .tok_to_mem  (tok_to_mem),
   .tok_dest    (tok_dest),
   .rsp_valid   (rsp_valid),
   .rsp_blk     (rsp_blk),
   .treq_valid  (treq_valid),
   .treq_ready  (treq_ready),
   .treq_blk    (treq_blk),
   .preq_valid  (preq_valid),
   .deact_valid (deact_valid)
);

// File: tb/test_tokc_node.sv
`timescale 1ns/1ps
module test_tokc_node;

   localparam int NB = 4, T = 4, RT = 8, PT = 32, MR = 4;
   localparam int BW = 2, CW = 3, NW = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic op_valid = 0, op_store = 0;  logic [BW-1:0] op_blk = '0;
   logic rsp_valid = 0, rsp_data = 0; logic [BW-1:0] rsp_blk = '0; logic [CW-1:0] rsp_tokens = '0;
   logic ptab_valid = 0, ptab_activate = 0; logic [BW-1:0] ptab_blk = '0; logic [NW-1:0] ptab_node = '0;
   logic evict_valid = 0; logic [BW-1:0] evict_blk = '0;
   logic tok_ready = 1, treq_ready = 1, preq_ready = 1, deact_ready = 1;
   logic op_done, evict_ready, tok_valid, tok_data, tok_to_mem;
   logic [BW-1:0] tok_blk, treq_blk, preq_blk, deact_blk;
   logic [CW-1:0] tok_tokens; logic [NW-1:0] tok_dest;
   logic treq_valid, treq_store, preq_valid, preq_store, deact_valid;

   always #4 clk = ~clk;

   tokc_node #(.NUM_BLOCKS(NB), .TOTAL_TOKENS(T), .NUM_NODES(4), .NODE_ID(0),
               .REQ_TIMEOUT(RT), .PERSIST_TIMEOUT(PT), .MAX_RETRY(MR)) i_tokc_node (.*);

   int nchk = 0, nfail = 0, cyc = 0, nmsg = 0, ntreq = 0, pstamp = -1;
   int tstamp [8];
   int exp_cnt [NB];
   int last_blk, last_tok, last_dst, last_mem, last_dat;
   bit esc_mode = 0, esc_early = 0, done_flag = 0;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   endtask

   always @(negedge clk) if (rst_n) begin
      cyc++;
      if (tok_valid && tok_ready) begin
         chk(int'(tok_tokens) == exp_cnt[tok_blk], "R1 message tokens", int'(tok_tokens), exp_cnt[tok_blk]);
         exp_cnt[tok_blk] = 0;
         last_blk = int'(tok_blk); last_tok = int'(tok_tokens); last_dst = int'(tok_dest);
         last_mem = int'(tok_to_mem); last_dat = int'(tok_data);
         nmsg++;
      end
      if (treq_valid && treq_ready) begin
         if (ntreq < 8) tstamp[ntreq] = cyc;
         ntreq++;
      end
      if (preq_valid && pstamp < 0) pstamp = cyc;
      if (esc_mode && op_done) esc_early = 1;
      if (cyc > 20000) begin
         chk(0, "watchdog", cyc, 20000);
         finish_run();
      end
   end

   task automatic settle(); @(negedge clk); #2; endtask

   task automatic rsp_send(input int b, input int n, input bit d);
      @(posedge clk); #1;
      rsp_valid = 1; rsp_blk = BW'(b); rsp_tokens = CW'(n); rsp_data = d;
      @(posedge clk); exp_cnt[b] += n; #1;
      rsp_valid = 0;
   endtask

   task automatic ptab(input bit act, input int b, input int n);
      @(posedge clk); #1;
      ptab_valid = 1; ptab_activate = act; ptab_blk = BW'(b); ptab_node = NW'(n);
      @(posedge clk); #1;
      ptab_valid = 0;
   endtask

   task automatic do_evict(input int b);
      int guard = 0;
      @(posedge clk); #1;
      evict_valid = 1; evict_blk = BW'(b);
      do begin @(negedge clk); guard++; end while (!evict_ready && guard < 50);
      @(posedge clk); #1;
      evict_valid = 0;
   endtask

   task automatic load_check(input int b, input bit st, input bit expv, input string req);
      @(posedge clk); #1;
      op_valid = 1; op_store = st; op_blk = BW'(b);
      @(negedge clk); #2;
      chk(op_done == expv, req, int'(op_done), int'(expv));
      @(posedge clk); #1;
      op_valid = 0;
   endtask

   initial begin
      int n0;
      for (int b = 0; b < NB; b++) exp_cnt[b] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      settle();
      // R1: reset state, nothing pending on any output channel
      chk(!tok_valid && !treq_valid && !preq_valid && !deact_valid, "R1 reset idle",
          int'(tok_valid | treq_valid | preq_valid | deact_valid), 0);
      // R10: replacing an empty block sends nothing (also shows count 0 after reset, R1)
      do_evict(3);
      settle();
      chk(nmsg == 0, "R10 empty replacement", nmsg, 0);

      // R2 R3 R4: sweep each block over every token count, tokens arriving unrequested
      for (int b = 0; b < NB; b++) begin
         for (int k = 1; k <= T; k++) begin
            rsp_send(b, 1, k == 1);
            load_check(b, 0, 1, "R2 R4 load with tokens");
            if (k == T) load_check(b, 1, 1, "R3 store with all tokens");
         end
         n0 = nmsg;
         do_evict(b);
         settle();
         chk(nmsg == n0 + 1, "R10 replacement message", nmsg, n0 + 1);
         chk(last_mem == 1 && last_dat == 1 && last_tok == T && last_blk == b,
             "R10 replacement fields", last_tok, T);
      end

      // R10: partial count without data
      rsp_send(2, 2, 0);
      n0 = nmsg;
      do_evict(2);
      settle();
      chk(nmsg == n0 + 1 && last_tok == 2 && last_dat == 0 && last_mem == 1,
          "R10 partial replacement", last_tok, 2);

      // R8: forwarding to an active persistent requester
      rsp_send(1, 3, 1);
      n0 = nmsg;
      ptab(1, 1, 2);
      settle();
      chk(nmsg == n0 + 1 && last_blk == 1 && last_dst == 2 && last_mem == 0 && last_dat == 1,
          "R8 forward held tokens", last_dst, 2);
      chk(last_tok == 3, "R8 forward count", last_tok, 3);
      rsp_send(1, 1, 0);
      settle();
      chk(nmsg == n0 + 2 && last_dst == 2 && last_tok == 1, "R8 forward later tokens", last_dst, 2);
      // R9: overwrite requester
      ptab(1, 1, 3);
      rsp_send(1, 1, 0);
      settle();
      chk(nmsg == n0 + 3 && last_dst == 3, "R9 overwrite requester", last_dst, 3);
      // R9: deactivate stops forwarding
      ptab(0, 1, 0);
      rsp_send(1, 1, 0);
      repeat (3) settle();
      chk(nmsg == n0 + 3, "R9 no forward after deactivate", nmsg, n0 + 3);
      load_check(1, 0, 1, "R9 tokens stay local");
      // R8: entry naming this node forwards nothing
      ptab(1, 1, 0);
      repeat (3) settle();
      chk(nmsg == n0 + 3, "R8 own entry not forwarded", nmsg, n0 + 3);
      ptab(0, 1, 0);
      do_evict(1);

      // R11: forward wins the token channel over a replacement
      rsp_send(2, 2, 0);
      rsp_send(3, 1, 0);
      @(posedge clk); #1;
      tok_ready = 0;
      evict_valid = 1; evict_blk = 2'd2;
      ptab_valid = 1; ptab_activate = 1; ptab_blk = 2'd3; ptab_node = 2'd1;
      @(posedge clk); #1;
      ptab_valid = 0;
      settle();
      chk(tok_valid && tok_blk == 2'd3 && !evict_ready, "R11 forward first", int'(tok_blk), 3);
      @(posedge clk); #1 tok_ready = 1;
      settle();
      chk(last_blk == 3 && last_dst == 1 && last_mem == 0, "R11 forward sent", last_blk, 3);
      settle();
      chk(last_blk == 2 && last_mem == 1 && last_tok == 2, "R11 replacement after forward", last_blk, 2);
      @(posedge clk); #1 evict_valid = 0;

      // R5 R6 R3 R7: store with T-1 tokens escalates to a persistent request
      rsp_send(0, T - 1, 1);
      ntreq = 0; pstamp = -1; esc_mode = 1;
      @(posedge clk); #1;
      op_valid = 1; op_store = 1; op_blk = 2'd0;
      while (pstamp < 0 && !done_flag) @(negedge clk);
      #2;
      chk(ntreq == MR, "R5 transient send count", ntreq, MR);
      chk(tstamp[1] - tstamp[0] == RT + 1, "R5 reissue spacing", tstamp[1] - tstamp[0], RT + 1);
      chk(pstamp - tstamp[MR-1] == RT + PT + 1, "R6 persistent delay", pstamp - tstamp[MR-1], RT + PT + 1);
      chk(preq_blk == 2'd0 && preq_store, "R6 persistent fields", int'(preq_blk), 0);
      chk(!esc_early, "R3 store withheld below total", int'(esc_early), 0);
      esc_mode = 0;
      rsp_send(0, 1, 0);
      settle();
      chk(op_done == 1'b1, "R3 store granted at total", int'(op_done), 1);
      @(posedge clk); #1 op_valid = 0;
      settle();
      chk(deact_valid && deact_blk == 2'd0, "R7 deactivate sent", int'(deact_valid), 1);
      settle();
      chk(!deact_valid && ntreq == MR, "R7 deactivate once", int'(deact_valid), 0);

      finish_run();
   end

endmodule